// File: doc/BRIEF.md
# VEX/XOP Escape Field Extractor

This block sits directly after legacy-prefix decoding in a 64-bit mode instruction decoder. Each cycle it may be offered a three-byte window that starts at the first byte following the legacy and REX prefixes. It also receives flags saying which of those prefixes the instruction carried, and the position of the window inside the instruction. It decides whether the first byte opens a two-byte VEX form (C5), a three-byte VEX form (C4) or an XOP form (8F with a map select of 8 or above). It also recognises the case where the byte is something else, including an 8F that is really a POP.

For an escape, the block unpacks the payload into plain, positive-logic fields. These are the register extension bits R, X and B, the opcode map number, W, the extra source register number, the vector length, and the implied SIMD prefix as a one-hot vector. It flags an undefined-opcode fault when the escape is illegal. It also reports the position of the opcode byte that follows the escape. Results appear one clock after the window is presented. Opcode decode and operand fetch are left to later stages.

Top module: `vex_field_extract`

## Requirements
- R1: `out_kind` is 1 when byte 0 of the window is C5 and 2 when it is C4. It is 3 when byte 0 is 8F and bits 4:0 of byte 1 are 8 or greater. In every other case, including 8F with a map select below 8, it is 0.
- R2: Each cycle with `in_valid` high produces exactly one result with `out_valid` high on the next clock, and no result appears otherwise. While reset is applied, and after it until the first input, every output is zero.
- R3: For kinds 2 and 3, `out_r`, `out_x` and `out_b` are the inverse of byte 1 bits 7, 6 and 5, and `out_map` equals byte 1 bits 4:0.
- R4: For kinds 2 and 3, `out_w` is byte 2 bit 7. `out_vreg` is the bitwise inverse of byte 2 bits 6:3, so 1111 gives register 0 and 0000 gives register 15. `out_len` is byte 2 bit 2, and the two-bit SIMD code is byte 2 bits 1:0.
- R5: For kind 1, `out_r` is the inverse of byte 1 bit 7 and `out_vreg` is the inverse of byte 1 bits 6:3. `out_len` is byte 1 bit 2 and the SIMD code is byte 1 bits 1:0. `out_map` is 1, and `out_x`, `out_b` and `out_w` are 0.
- R6: `out_simd` is one-hot from the SIMD code: 00 gives 000, 01 (66) gives bit 0, 10 (F3) gives bit 1, and 11 (F2) gives bit 2.
- R7: `out_ud` is 1 for any nonzero kind when any of `in_pfx_66`, `in_pfx_f2`, `in_pfx_f3`, `in_pfx_lock` or `in_pfx_rex` is set. The payload fields are still reported.
- R8: `out_ud` is 1 for kind 2 when the map select is 0.
- R9: `out_opc_idx` is `in_pos` + 2 for kind 1, `in_pos` + 3 for kinds 2 and 3, and `in_pos` for kind 0. The sum is taken modulo 2^IDX_W.
- R10: For kind 0, `out_ud` and all payload fields are zero, whatever the prefix flags are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Window is valid this cycle |
| in_pos | input | IDX_W | Position of window byte 0 inside the instruction |
| in_bytes | input | 8*WIN_BYTES | Window; byte 0 in bits 7:0 |
| in_pfx_66 | input | 1 | Operand-size prefix seen |
| in_pfx_f2 | input | 1 | F2 prefix seen |
| in_pfx_f3 | input | 1 | F3 prefix seen |
| in_pfx_lock | input | 1 | LOCK prefix seen |
| in_pfx_rex | input | 1 | REX prefix seen |
| out_valid | output | 1 | Result valid |
| out_kind | output | 2 | 0 none, 1 two-byte VEX, 2 three-byte VEX, 3 XOP |
| out_ud | output | 1 | Undefined-opcode fault |
| out_r | output | 1 | Register extension for the ModRM reg field |
| out_x | output | 1 | Register extension for the SIB index |
| out_b | output | 1 | Register extension for the base or r/m field |
| out_map | output | 5 | Opcode map number |
| out_w | output | 1 | W bit |
| out_vreg | output | 4 | Extra source register number, positive logic |
| out_len | output | 1 | Vector length: 0 for 128-bit, 1 for 256-bit |
| out_simd | output | 3 | Implied prefix, one-hot: bit 0 is 66, bit 1 is F3, bit 2 is F2 |
| out_opc_idx | output | IDX_W | Position of the opcode byte |

## Verification
The timing assertions assume that `in_valid` is never unknown once reset is released. The payload assertions compare an output with the window bits sampled one clock earlier, so they assume that the upstream stage always presents all three window bytes with a valid beat. The bench always drives a full, defined window with every beat and keeps `in_pos` small enough that the opcode position does not wrap. It offers prefix flags one at a time, so each fault cause is seen on its own. Idle cycles carry escape-looking garbage, which shows that nothing is taken in without `in_valid`.

// File: rtl/vex_xtr_pkg.sv
package vex_xtr_pkg;

  typedef enum logic [1:0] {
    ESC_NONE = 2'd0,
    ESC_VEX2 = 2'd1,
    ESC_VEX3 = 2'd2,
    ESC_XOP  = 2'd3
  } esc_kind_e;

  localparam logic [7:0] ESC_BYTE_2B  = 8'hC5;
  localparam logic [7:0] ESC_BYTE_3B  = 8'hC4;
  localparam logic [7:0] ESC_BYTE_XOP = 8'h8F;

  localparam int MAP_W  = 5;
  localparam int VREG_W = 4;
  localparam int SIMD_W = 3;

  typedef struct packed {
    logic              r;
    logic              x;
    logic              b;
    logic [MAP_W-1:0]  map;
    logic              w;
    logic [VREG_W-1:0] vreg;
    logic              len;
    logic [SIMD_W-1:0] simd;
  } vex_fields_t;

endpackage

// File: rtl/vex_esc_classify.sv
module vex_esc_classify
  import vex_xtr_pkg::*;
#(
  parameter int XOP_MAP_MIN = 8
) (
  input  logic [7:0]       esc_byte,
  input  logic [MAP_W-1:0] map_field,
  output esc_kind_e        kind
);

  localparam logic [MAP_W-1:0] XOP_FLOOR = MAP_W'(XOP_MAP_MIN);

  logic map_is_xop;

  // An 8F whose map select lies below the floor is a POP and not an escape.
  assign map_is_xop = (map_field >= XOP_FLOOR);

  always_comb begin
    kind = ESC_NONE;
    if (esc_byte == ESC_BYTE_2B) begin
      kind = ESC_VEX2;
    end else if (esc_byte == ESC_BYTE_3B) begin
      kind = ESC_VEX3;
    end else if ((esc_byte == ESC_BYTE_XOP) && map_is_xop) begin
      kind = ESC_XOP;
    end
  end

endmodule

// File: rtl/vex_payload_unpack.sv
module vex_payload_unpack
  import vex_xtr_pkg::*;
(
  input  esc_kind_e   kind,
  input  logic [7:0]  pay1,
  input  logic [7:0]  pay2,
  output vex_fields_t fields
);

  logic [1:0]        pp_sel;
  logic [SIMD_W-1:0] simd_hot;

  // The SIMD code sits in the last payload byte of each form.
  assign pp_sel = (kind == ESC_VEX2) ? pay1[1:0] :
                  (kind == ESC_NONE) ? 2'b00     : pay2[1:0];

  // Codes 1, 2 and 3 map onto one-hot positions 0, 1 and 2.
  for (genvar gi = 0; gi < SIMD_W; gi++) begin : g_simd
    assign simd_hot[gi] = (pp_sel == 2'(gi + 1));
  end

  always_comb begin
    fields = '0;
    unique case (kind)
      ESC_VEX2: begin
        fields.r    = ~pay1[7];
        fields.map  = MAP_W'(1);
        fields.vreg = ~pay1[6:3];
        fields.len  = pay1[2];
        fields.simd = simd_hot;
      end
      ESC_VEX3, ESC_XOP: begin
        fields.r    = ~pay1[7];
        fields.x    = ~pay1[6];
        fields.b    = ~pay1[5];
        fields.map  = pay1[4:0];
        fields.w    = pay2[7];
        fields.vreg = ~pay2[6:3];
        fields.len  = pay2[2];
        fields.simd = simd_hot;
      end
      default: fields = '0;
    endcase
  end

endmodule

// File: rtl/vex_fault_check.sv
module vex_fault_check
  import vex_xtr_pkg::*;
(
  input  esc_kind_e        kind,
  input  logic [MAP_W-1:0] map_field,
  input  logic             pfx_66,
  input  logic             pfx_f2,
  input  logic             pfx_f3,
  input  logic             pfx_lock,
  input  logic             pfx_rex,
  output logic             ud
);

  logic legacy_clash;
  logic reserved_map;

  assign legacy_clash = pfx_66 | pfx_f2 | pfx_f3 | pfx_lock | pfx_rex;
  assign reserved_map = (kind == ESC_VEX3) && (map_field == '0);
  assign ud           = (kind != ESC_NONE) && (legacy_clash || reserved_map);

endmodule

// File: rtl/vex_field_extract.sv
module vex_field_extract
  import vex_xtr_pkg::*;
#(
  parameter int WIN_BYTES   = 3,
  parameter int IDX_W       = 4,
  parameter int XOP_MAP_MIN = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic [IDX_W-1:0]       in_pos,
  input  logic [8*WIN_BYTES-1:0] in_bytes,
  input  logic                   in_pfx_66,
  input  logic                   in_pfx_f2,
  input  logic                   in_pfx_f3,
  input  logic                   in_pfx_lock,
  input  logic                   in_pfx_rex,
  output logic                   out_valid,
  output logic [1:0]             out_kind,
  output logic                   out_ud,
  output logic                   out_r,
  output logic                   out_x,
  output logic                   out_b,
  output logic [MAP_W-1:0]       out_map,
  output logic                   out_w,
  output logic [VREG_W-1:0]      out_vreg,
  output logic                   out_len,
  output logic [SIMD_W-1:0]      out_simd,
  output logic [IDX_W-1:0]       out_opc_idx
);

  localparam logic [IDX_W-1:0] STEP_2B = IDX_W'(2);
  localparam logic [IDX_W-1:0] STEP_3B = IDX_W'(3);

  // Reset synchroniser: the reset is applied asynchronously and released on a clock edge.
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [7:0] esc_byte, pay1, pay2;
  assign esc_byte = in_bytes[7:0];
  assign pay1     = in_bytes[15:8];
  assign pay2     = in_bytes[23:16];

  esc_kind_e   kind_c;
  vex_fields_t fields_c;
  logic        ud_c;

  vex_esc_classify #(.XOP_MAP_MIN(XOP_MAP_MIN)) u_classify (
    .esc_byte (esc_byte),
    .map_field(pay1[4:0]),
    .kind     (kind_c)
  );

  vex_payload_unpack u_unpack (
    .kind  (kind_c),
    .pay1  (pay1),
    .pay2  (pay2),
    .fields(fields_c)
  );

  vex_fault_check u_fault (
    .kind     (kind_c),
    .map_field(pay1[4:0]),
    .pfx_66   (in_pfx_66),
    .pfx_f2   (in_pfx_f2),
    .pfx_f3   (in_pfx_f3),
    .pfx_lock (in_pfx_lock),
    .pfx_rex  (in_pfx_rex),
    .ud       (ud_c)
  );

  // Next-state logic
  logic             valid_d;
  esc_kind_e        kind_d;
  logic             ud_d;
  vex_fields_t      fields_d;
  logic [IDX_W-1:0] opc_d;

  always_comb begin
    valid_d  = in_valid;
    kind_d   = kind_c;
    ud_d     = ud_c;
    fields_d = fields_c;
    unique case (kind_c)
      ESC_VEX2:          opc_d = in_pos + STEP_2B;
      ESC_VEX3, ESC_XOP: opc_d = in_pos + STEP_3B;
      default:           opc_d = in_pos;
    endcase
  end

  // Register stage; the payload registers load only on a valid beat.
  logic             valid_q;
  esc_kind_e        kind_q;
  logic             ud_q;
  vex_fields_t      fields_q;
  logic [IDX_W-1:0] opc_q;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      kind_q   <= ESC_NONE;
      ud_q     <= 1'b0;
      fields_q <= '0;
      opc_q    <= '0;
    end else if (in_valid) begin
      kind_q   <= kind_d;
      ud_q     <= ud_d;
      fields_q <= fields_d;
      opc_q    <= opc_d;
    end
  end

  assign out_valid   = valid_q;
  assign out_kind    = kind_q;
  assign out_ud      = ud_q;
  assign out_r       = fields_q.r;
  assign out_x       = fields_q.x;
  assign out_b       = fields_q.b;
  assign out_map     = fields_q.map;
  assign out_w       = fields_q.w;
  assign out_vreg    = fields_q.vreg;
  assign out_len     = fields_q.len;
  assign out_simd    = fields_q.simd;
  assign out_opc_idx = opc_q;

  // Assertions
  AST_ONE_CYCLE_RESULT: assert property (@(posedge clk) disable iff (!rst_int_n)
    out_valid |-> $past(in_valid)); // R2

  AST_XOP_MAP_FLOOR: assert property (@(posedge clk) disable iff (!rst_int_n)
    (out_valid && kind_q == ESC_XOP) |-> (out_map >= MAP_W'(XOP_MAP_MIN))); // R1

  AST_LONG_FORM_EXT: assert property (@(posedge clk) disable iff (!rst_int_n)
    (out_valid && (kind_q == ESC_VEX3 || kind_q == ESC_XOP))
      |-> ({out_r, out_x, out_b} == ~$past(in_bytes[15:13]))); // R3

  AST_VREG_INVERTED: assert property (@(posedge clk) disable iff (!rst_int_n)
    (out_valid && (kind_q == ESC_VEX3 || kind_q == ESC_XOP))
      |-> (out_vreg == ~$past(in_bytes[22:19]))); // R4

  AST_SHORT_FORM_FIXED: assert property (@(posedge clk) disable iff (!rst_int_n)
    (out_valid && kind_q == ESC_VEX2)
      |-> (out_map == MAP_W'(1) && !out_x && !out_b && !out_w)); // R5

  AST_SIMD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_int_n)
    $onehot0(out_simd)); // R6

  AST_PREFIX_FAULT: assert property (@(posedge clk) disable iff (!rst_int_n)
    (out_valid && kind_q != ESC_NONE &&
     $past(in_pfx_66 | in_pfx_f2 | in_pfx_f3 | in_pfx_lock | in_pfx_rex)) |-> out_ud); // R7

  AST_MAP0_FAULT: assert property (@(posedge clk) disable iff (!rst_int_n)
    (out_valid && kind_q == ESC_VEX3 && out_map == '0) |-> out_ud); // R8

  AST_OPC_AFTER_LONG: assert property (@(posedge clk) disable iff (!rst_int_n)
    (out_valid && (kind_q == ESC_VEX3 || kind_q == ESC_XOP))
      |-> (out_opc_idx == IDX_W'($past(in_pos) + STEP_3B))); // R9

  AST_NONE_QUIET: assert property (@(posedge clk) disable iff (!rst_int_n)
    (out_valid && kind_q == ESC_NONE)
      |-> (!out_ud && out_map == '0 && out_vreg == '0 && out_simd == '0 &&
           !out_r && !out_x && !out_b && !out_w && !out_len)); // R10

endmodule

// File: tb/vex_field_extract_bench.sv
module vex_field_extract_bench;

  localparam int IDX_W = 4;
  localparam int VEC_W = 2 + 1 + 3 + 5 + 1 + 4 + 1 + 3 + IDX_W;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             in_valid;
  logic [IDX_W-1:0] in_pos;
  logic [23:0]      in_bytes;
  logic             in_pfx_66, in_pfx_f2, in_pfx_f3, in_pfx_lock, in_pfx_rex;
  logic             out_valid;
  logic [1:0]       out_kind;
  logic             out_ud, out_r, out_x, out_b, out_w, out_len;
  logic [4:0]       out_map;
  logic [3:0]       out_vreg;
  logic [2:0]       out_simd;
  logic [IDX_W-1:0] out_opc_idx;

  always #2 clk = ~clk;

  vex_field_extract u_vex_field_extract (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pos(in_pos), .in_bytes(in_bytes),
    .in_pfx_66(in_pfx_66), .in_pfx_f2(in_pfx_f2), .in_pfx_f3(in_pfx_f3),
    .in_pfx_lock(in_pfx_lock), .in_pfx_rex(in_pfx_rex),
    .out_valid(out_valid), .out_kind(out_kind), .out_ud(out_ud), .out_r(out_r),
    .out_x(out_x), .out_b(out_b), .out_map(out_map), .out_w(out_w), .out_vreg(out_vreg),
    .out_len(out_len), .out_simd(out_simd), .out_opc_idx(out_opc_idx)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [VEC_W-1:0] exp_q[$];
  string            tag_q[$];

  // Prefix vector order used by the bench: bit0 66, bit1 F2, bit2 F3, bit3 LOCK, bit4 REX.
  function automatic logic [VEC_W-1:0] model(input logic [IDX_W-1:0] pos,
      input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2,
      input logic [4:0] pfx);
    logic [1:0] k; logic ud, r, x, b, w, l; logic [4:0] m; logic [3:0] v;
    logic [1:0] pp; logic [2:0] s; logic [IDX_W-1:0] o;
    k = 2'd0; ud = 0; r = 0; x = 0; b = 0; w = 0; l = 0; m = 0; v = 0; pp = 0; o = pos;
    if (b0 == 8'hC5) k = 2'd1;
    else if (b0 == 8'hC4) k = 2'd2;
    else if (b0 == 8'h8F && b1[4:0] >= 5'd8) k = 2'd3;
    if (k == 2'd1) begin
      r = ~b1[7]; v = ~b1[6:3]; l = b1[2]; pp = b1[1:0]; m = 5'd1; o = pos + 2;
    end else if (k != 2'd0) begin
      r = ~b1[7]; x = ~b1[6]; b = ~b1[5]; m = b1[4:0];
      w = b2[7]; v = ~b2[6:3]; l = b2[2]; pp = b2[1:0]; o = pos + 3;
    end
    case (pp)
      2'b01:   s = 3'b001;
      2'b10:   s = 3'b010;
      2'b11:   s = 3'b100;
      default: s = 3'b000;
    endcase
    if (k != 2'd0) ud = (pfx != 5'd0) || (k == 2'd2 && m == 5'd0);
    return {k, ud, r, x, b, m, w, v, l, s, o};
  endfunction

  function automatic logic [VEC_W-1:0] actual();
    return {out_kind, out_ud, out_r, out_x, out_b, out_map, out_w, out_vreg,
            out_len, out_simd, out_opc_idx};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [VEC_W-1:0] act,
                       input logic [VEC_W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver: called at a falling edge, returns at the next falling edge.
  task automatic send(input int pos, input logic [7:0] b0, input logic [7:0] b1,
                      input logic [7:0] b2, input logic [4:0] pfx, input string tag);
    in_valid = 1'b1;
    in_pos   = IDX_W'(pos);
    in_bytes = {b2, b1, b0};
    {in_pfx_rex, in_pfx_lock, in_pfx_f3, in_pfx_f2, in_pfx_66} = pfx;
    exp_q.push_back(model(IDX_W'(pos), b0, b1, b2, pfx));
    tag_q.push_back(tag);
    @(negedge clk);
  endtask

  task automatic idle_check();
    in_valid = 1'b0;
    in_bytes = 24'h79E2C4;
    {in_pfx_rex, in_pfx_lock, in_pfx_f3, in_pfx_f2, in_pfx_66} = 5'd0;
    @(posedge clk); #1;
    check(out_valid == 1'b0, "R2 idle cycle gives no result", VEC_W'(out_valid), '0);
    @(negedge clk);
  endtask

  // Monitor: pops the scoreboard as results appear, just after the rising edge.
  initial begin
    forever begin
      @(posedge clk); #1;
      if (rst_n && out_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R2 unexpected result", actual(), '0);
        end else begin
          logic [VEC_W-1:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(actual() === e, t, actual(), e);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_pos = '0; in_bytes = '0;
    {in_pfx_rex, in_pfx_lock, in_pfx_f3, in_pfx_f2, in_pfx_66} = 5'd0;
    repeat (3) @(posedge clk); #1;
    check({out_valid, actual()} == '0, "R2 outputs zero in reset", actual(), '0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check({out_valid, actual()} == '0, "R2 outputs zero after reset", actual(), '0);

    send(0, 8'hC5, 8'hF8, 8'h77, 5'd0, "R5 two-byte form, all inverted bits set");
    send(1, 8'hC5, 8'h45, 8'h00, 5'd0, "R5 R6 two-byte form R=1 vreg=7 L=1 pp=66");
    send(2, 8'hC5, 8'h7C, 8'h00, 5'd0, "R5 two-byte form L=1 no prefix");
    send(2, 8'hC4, 8'hE2, 8'h79, 5'd0, "R3 R4 three-byte form map 2");
    send(0, 8'hC4, 8'h41, 8'hFD, 5'd0, "R3 R4 three-byte R=1 X=0 B=1 W=1");
    send(3, 8'hC4, 8'hE0, 8'h78, 5'd0, "R8 three-byte map 0 faults");
    send(4, 8'hC4, 8'hE3, 8'h7B, 5'd0, "R3 R6 three-byte map 3 pp=F2");
    idle_check();
    send(0, 8'h8F, 8'hE9, 8'h78, 5'd0, "R1 XOP map 9");
    send(1, 8'h8F, 8'hE8, 8'h00, 5'd0, "R1 XOP lowest map 8");
    send(5, 8'h8F, 8'hFF, 8'hAA, 5'd0, "R1 XOP highest map 1F");
    send(0, 8'h8F, 8'hC7, 8'h00, 5'd0, "R1 R10 8F map 7 is POP");
    send(5, 8'h8F, 8'hC0, 8'h00, 5'd1, "R10 POP with 66 has no fault");
    send(7, 8'h48, 8'h89, 8'hE5, 5'd0, "R10 R9 plain opcode byte");
    send(6, 8'h62, 8'hF1, 8'h7C, 5'd16, "R10 unrelated byte with REX");
    for (int i = 0; i < 5; i++) begin
      send(0, 8'hC5, 8'hF8, 8'h00, 5'(1 << i), "R7 two-byte form with prefix");
      send(1, 8'hC4, 8'hE2, 8'h79, 5'(1 << i), "R7 three-byte form with prefix");
      send(2, 8'h8F, 8'hE9, 8'h78, 5'(1 << i), "R7 XOP with prefix");
    end
    for (int p = 0; p < 4; p++) begin
      send(p, 8'hC4, 8'hE1, {1'b0, 4'hF, 1'b0, 2'(p)}, 5'd0, "R6 SIMD code sweep");
    end
    idle_check();
    for (int v = 0; v < 16; v++) begin
      send(v % 8, 8'hC4, 8'hE1, {1'b1, 4'(v), 1'b1, 2'b00}, 5'd0, "R4 R9 vvvv sweep");
    end
    for (int v = 0; v < 16; v += 5) begin
      send(3, 8'hC5, {1'b1, 4'(v), 1'b0, 2'b10}, 8'h00, 5'd0, "R5 R9 two-byte vvvv");
    end

    in_valid = 1'b0;
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R2 every beat produced a result",
          VEC_W'(exp_q.size()), '0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule